// File: doc/BRIEF.md
# Mode-Dependent CPU Register File

This block holds the programmer-visible registers of a processor core that runs in three compatibility levels: a base 8-bit level, an extended level, and a 32-bit level. A mode register inside the block chooses the level. The level decides which registers can be selected and how wide the pointer-class registers are. The byte accumulators A, B, E and F are the only storage for the wide arithmetic registers. The 16-, 32- and 64-bit accumulator views (D, W, Q, O) are concatenations of those bytes and of V, so a write through a wide view updates the bytes underneath it.

The core reaches the block through two combinational read ports and one write port. Each port is addressed by a 5-bit register code. Transfer and exchange instructions can use a zero register that always reads 0 and discards writes. The zero register is removed in the 32-bit level. Software can always write the mode register. Its low byte decodes into control outputs for the interrupt and trap logic. Two event strobes from the core set sticky flags for an illegal instruction and a division by zero. In the 32-bit level, the upper 24 bits of the mode register drive a mask output for the extra interrupt lines.

Top module: `modal_regfile`

## Requirements
- R1: After synchronous reset, every register and every mode bit is 0. The block is then in the base level, both flags are clear, and all reads return 0.
- R2: Mode bits: bit0 extended enable, bit1 fast-IRQ-as-normal, bit2 edge-triggered extra IRQs, bit3 IRQ hold after entry, bit4 32-bit enable, bit5 FPU enable, bit6 illegal flag, bit7 divide flag. `mode_wide` is bit0 AND bit4, and `mode_fpu` is bit0 AND bit5. The other outputs follow their own bit directly.
- R3: Register codes are D=0, X=1, Y=2, U=3, S=4, PC=5, W=6, V=7, A=8, B=9, CC=10, DP=11, ZERO=12, MODE=13, E=14, F=15, Q=16, O=17 and DS=18. Codes 19 to 31 never exist. The base level has D, X, Y, U, S, PC, A, B, CC, DP, ZERO and MODE. The extended level adds E, F, W, Q and V. The 32-bit level adds O and DS and drops ZERO. Reading an absent code sets that port's bad flag and returns 0. Writing an absent code changes nothing and raises `wr_bad`.
- R4: D = {A,B}, W = {E,F}, Q = {D,W} and O = {Q,V}, with the left operand in the upper bits. Writing a view updates every component it covers.
- R5: A, B, E, F, CC and DP are 8 bits wide. D, W, ZERO and DS are 16. Q is 32 and O is 64. X, Y, U, S, PC and V are 32 bits in the 32-bit level and 16 bits otherwise. A write stores its data truncated to the current width and clears the bits above. Reads are zero-extended to 64 bits.
- R6: The zero register reads 0 without a bad flag wherever it exists. A write to it leaves every register unchanged.
- R7: The mode register accepts writes in every level. In the 32-bit level it is 32 bits wide and bits 31:8 drive `irq_mask`. Otherwise it is 8 bits wide, a write clears bits 31:8, and `irq_mask` reads 0.
- R8: `ev_illegal` sets bit6 and `ev_divzero` sets bit7 at the next edge. The bits stay set until a mode write clears them. An event in the same cycle as such a write leaves its bit set.
- R9: Reads show the state as of the last clock edge. Two ports that select the same code return the same value, and a write becomes visible in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_a | input | 5 | Register code, read port A |
| rd_sel_b | input | 5 | Register code, read port B |
| rd_data_a | output | 64 | Read data, port A, zero-extended |
| rd_data_b | output | 64 | Read data, port B, zero-extended |
| rd_bad_a | output | 1 | Port A code absent in current level |
| rd_bad_b | output | 1 | Port B code absent in current level |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Register code for the write |
| wr_data | input | 64 | Write data, right-aligned |
| wr_bad | output | 1 | Write targets an absent code (ignored) |
| ev_illegal | input | 1 | Illegal instruction event strobe |
| ev_divzero | input | 1 | Division by zero event strobe |
| mode_ext | output | 1 | Extended level active |
| mode_firq_slow | output | 1 | Fast IRQ handled as normal IRQ |
| mode_edge_trig | output | 1 | Extra IRQ lines edge-triggered |
| mode_irq_hold | output | 1 | IRQs held off after entry |
| mode_wide | output | 1 | 32-bit level active |
| mode_fpu | output | 1 | FPU enabled (valid in extended level only) |
| flag_illegal | output | 1 | Sticky illegal instruction flag |
| flag_divzero | output | 1 | Sticky division by zero flag |
| irq_mask | output | 24 | Extra IRQ masks, 0 outside 32-bit level |

## Verification
Two things can happen in the same cycle. A software write to the mode register can clear a sticky flag while the core raises the event that sets that flag. A mode write can also change the level while the read ports sample under the old level. The bench provokes both cases. The random stream mixes mode writes with random flag bits and event strobes, and directed steps place a flag-clearing write and an event on the same edge. Each case is judged against a bench model that applies the write first and then ORs in the events. Reads are compared in the cycle before the edge, using the widths and existence rules of the level that held before that edge.

// File: rtl/modal_regfile_pkg.sv
package modal_regfile_pkg;

    localparam int SEL_W    = 5;
    localparam int DATA_W   = 64;
    localparam int PTR_W    = 32;
    localparam int NARROW_W = 16;
    localparam int BYTE_W   = 8;
    localparam int MASK_W   = 24;
    localparam int QUAD_W   = 4 * BYTE_W;
    localparam int NUM_PTR  = 5;
    localparam int NUM_RD   = 2;
    localparam int SLOT_W   = $clog2(NUM_PTR);

    typedef enum logic [SEL_W-1:0] {
        RC_D    = 5'd0,
        RC_X    = 5'd1,
        RC_Y    = 5'd2,
        RC_U    = 5'd3,
        RC_S    = 5'd4,
        RC_PC   = 5'd5,
        RC_W    = 5'd6,
        RC_V    = 5'd7,
        RC_A    = 5'd8,
        RC_B    = 5'd9,
        RC_CC   = 5'd10,
        RC_DP   = 5'd11,
        RC_ZERO = 5'd12,
        RC_MODE = 5'd13,
        RC_E    = 5'd14,
        RC_F    = 5'd15,
        RC_Q    = 5'd16,
        RC_O    = 5'd17,
        RC_DS   = 5'd18
    } reg_code_e;

    // Low byte of the mode register; bit 0 is the last field.
    typedef struct packed {
        logic div_flag;
        logic ill_flag;
        logic fpu_en;
        logic wide_en;
        logic irq_hold;
        logic edge_trig;
        logic firq_slow;
        logic ext_en;
    } mode_t;

    typedef struct packed {
        logic [BYTE_W-1:0]              a;
        logic [BYTE_W-1:0]              b;
        logic [BYTE_W-1:0]              e;
        logic [BYTE_W-1:0]              f;
        logic [BYTE_W-1:0]              cc;
        logic [BYTE_W-1:0]              dp;
        logic [NUM_PTR-1:0][PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]               v;
        logic [NARROW_W-1:0]            ds;
        logic [MASK_W-1:0]              irq_mask;
        mode_t                          md;
    } arch_state_t;

    typedef struct packed {
        logic               a;
        logic               b;
        logic               e;
        logic               f;
        logic               cc;
        logic               dp;
        logic [NUM_PTR-1:0] ptr;
        logic               v;
        logic               ds;
        logic               mode;
    } wr_enable_t;

    function automatic logic [SLOT_W-1:0] ptr_slot(logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] off;
        off = sel - SEL_W'(RC_X);
        return off[SLOT_W-1:0];
    endfunction

    function automatic logic reg_present(logic [SEL_W-1:0] sel, logic ext, logic wide);
        logic p;
        case (sel)
            RC_D, RC_X, RC_Y, RC_U, RC_S, RC_PC,
            RC_A, RC_B, RC_CC, RC_DP, RC_MODE:  p = 1'b1;
            RC_ZERO:                            p = ~wide;
            RC_E, RC_F, RC_W, RC_Q, RC_V:       p = ext;
            RC_O, RC_DS:                        p = wide;
            default:                            p = 1'b0;
        endcase
        return p;
    endfunction

    function automatic int reg_bits(logic [SEL_W-1:0] sel, logic wide);
        int w;
        case (sel)
            RC_A, RC_B, RC_E, RC_F, RC_CC, RC_DP: w = BYTE_W;
            RC_D, RC_W, RC_ZERO, RC_DS:           w = NARROW_W;
            RC_Q:                                 w = QUAD_W;
            RC_O:                                 w = DATA_W;
            RC_X, RC_Y, RC_U, RC_S, RC_PC, RC_V:  w = wide ? PTR_W : NARROW_W;
            RC_MODE:                              w = wide ? (BYTE_W + MASK_W) : BYTE_W;
            default:                              w = 0;
        endcase
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(int w);
        logic [DATA_W-1:0] one;
        one = DATA_W'(1);
        if (w >= DATA_W) return '1;
        return (one << w) - one;
    endfunction

    function automatic logic [DATA_W-1:0] raw_read(logic [SEL_W-1:0] sel, arch_state_t st);
        logic [DATA_W-1:0] r;
        r = '0;
        case (sel)
            RC_A:    r[BYTE_W-1:0]   = st.a;
            RC_B:    r[BYTE_W-1:0]   = st.b;
            RC_E:    r[BYTE_W-1:0]   = st.e;
            RC_F:    r[BYTE_W-1:0]   = st.f;
            RC_CC:   r[BYTE_W-1:0]   = st.cc;
            RC_DP:   r[BYTE_W-1:0]   = st.dp;
            RC_D:    r[NARROW_W-1:0] = {st.a, st.b};
            RC_W:    r[NARROW_W-1:0] = {st.e, st.f};
            RC_Q:    r[QUAD_W-1:0]   = {st.a, st.b, st.e, st.f};
            RC_O:    r               = {st.a, st.b, st.e, st.f, st.v};
            RC_X, RC_Y, RC_U, RC_S, RC_PC:
                     r[PTR_W-1:0]    = st.ptr[ptr_slot(sel)];
            RC_V:    r[PTR_W-1:0]    = st.v;
            RC_DS:   r[NARROW_W-1:0] = st.ds;
            RC_MODE: r[BYTE_W+MASK_W-1:0] = {st.irq_mask, st.md};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrf_read_port.sv
module mrf_read_port
    import modal_regfile_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  arch_state_t       st,
    input  logic              ext,
    input  logic              wide,
    output logic [DATA_W-1:0] data,
    output logic              bad
);
    logic present;

    always_comb begin
        present = reg_present(sel, ext, wide);
        bad     = ~present;
        data    = present ? (raw_read(sel, st) & width_mask(reg_bits(sel, wide))) : '0;
    end
endmodule

// File: rtl/mrf_write_decode.sv
module mrf_write_decode
    import modal_regfile_pkg::*;
(
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext,
    input  logic              wide,
    output logic              wr_bad,
    output wr_enable_t        en,
    output arch_state_t       wval
);
    logic              present;
    logic [DATA_W-1:0] d;

    always_comb begin
        present = reg_present(wr_sel, ext, wide);
        wr_bad  = wr_en & ~present;
        d       = wr_data & width_mask(reg_bits(wr_sel, wide));
        en      = '0;
        wval    = '0;
        if (wr_en && present) begin
            case (wr_sel)
                RC_A:  begin en.a  = 1'b1; wval.a  = d[0*BYTE_W +: BYTE_W]; end
                RC_B:  begin en.b  = 1'b1; wval.b  = d[0*BYTE_W +: BYTE_W]; end
                RC_E:  begin en.e  = 1'b1; wval.e  = d[0*BYTE_W +: BYTE_W]; end
                RC_F:  begin en.f  = 1'b1; wval.f  = d[0*BYTE_W +: BYTE_W]; end
                RC_CC: begin en.cc = 1'b1; wval.cc = d[0*BYTE_W +: BYTE_W]; end
                RC_DP: begin en.dp = 1'b1; wval.dp = d[0*BYTE_W +: BYTE_W]; end
                RC_D: begin
                    en.a = 1'b1; wval.a = d[1*BYTE_W +: BYTE_W];
                    en.b = 1'b1; wval.b = d[0*BYTE_W +: BYTE_W];
                end
                RC_W: begin
                    en.e = 1'b1; wval.e = d[1*BYTE_W +: BYTE_W];
                    en.f = 1'b1; wval.f = d[0*BYTE_W +: BYTE_W];
                end
                RC_Q: begin
                    en.a = 1'b1; wval.a = d[3*BYTE_W +: BYTE_W];
                    en.b = 1'b1; wval.b = d[2*BYTE_W +: BYTE_W];
                    en.e = 1'b1; wval.e = d[1*BYTE_W +: BYTE_W];
                    en.f = 1'b1; wval.f = d[0*BYTE_W +: BYTE_W];
                end
                RC_O: begin
                    en.a = 1'b1; wval.a = d[7*BYTE_W +: BYTE_W];
                    en.b = 1'b1; wval.b = d[6*BYTE_W +: BYTE_W];
                    en.e = 1'b1; wval.e = d[5*BYTE_W +: BYTE_W];
                    en.f = 1'b1; wval.f = d[4*BYTE_W +: BYTE_W];
                    en.v = 1'b1; wval.v = d[PTR_W-1:0];
                end
                RC_X, RC_Y, RC_U, RC_S, RC_PC: begin
                    en.ptr[ptr_slot(wr_sel)]   = 1'b1;
                    wval.ptr[ptr_slot(wr_sel)] = d[PTR_W-1:0];
                end
                RC_V:  begin en.v  = 1'b1; wval.v  = d[PTR_W-1:0]; end
                RC_DS: begin en.ds = 1'b1; wval.ds = d[NARROW_W-1:0]; end
                RC_MODE: begin
                    en.mode       = 1'b1;
                    wval.md       = mode_t'(d[BYTE_W-1:0]);
                    wval.irq_mask = d[BYTE_W +: MASK_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mrf_store.sv
module mrf_store
    import modal_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wr_enable_t  en,
    input  arch_state_t wval,
    input  logic        ev_illegal,
    input  logic        ev_divzero,
    output arch_state_t st
);
    logic [BYTE_W-1:0]   a_q, b_q, e_q, f_q, cc_q, dp_q;
    logic [PTR_W-1:0]    ptr_q [NUM_PTR];
    logic [PTR_W-1:0]    v_q;
    logic [NARROW_W-1:0] ds_q;
    logic [MASK_W-1:0]   mask_q, mask_n;
    mode_t               md_q, md_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            e_q  <= '0;
            f_q  <= '0;
            cc_q <= '0;
            dp_q <= '0;
            v_q  <= '0;
            ds_q <= '0;
        end else begin
            if (en.a)  a_q  <= wval.a;
            if (en.b)  b_q  <= wval.b;
            if (en.e)  e_q  <= wval.e;
            if (en.f)  f_q  <= wval.f;
            if (en.cc) cc_q <= wval.cc;
            if (en.dp) dp_q <= wval.dp;
            if (en.v)  v_q  <= wval.v;
            if (en.ds) ds_q <= wval.ds;
        end
    end

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)            ptr_q[i] <= '0;
            else if (en.ptr[i]) ptr_q[i] <= wval.ptr[i];
        end
    end

    // Software write applies first; event strobes are OR-ed on top so none is lost.
    always_comb begin
        md_n          = en.mode ? wval.md : md_q;
        md_n.ill_flag = md_n.ill_flag | ev_illegal;
        md_n.div_flag = md_n.div_flag | ev_divzero;
        mask_n        = en.mode ? wval.irq_mask : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            md_q   <= '0;
            mask_q <= '0;
        end else begin
            md_q   <= md_n;
            mask_q <= mask_n;
        end
    end

    always_comb begin
        st.a        = a_q;
        st.b        = b_q;
        st.e        = e_q;
        st.f        = f_q;
        st.cc       = cc_q;
        st.dp       = dp_q;
        st.v        = v_q;
        st.ds       = ds_q;
        st.irq_mask = mask_q;
        st.md       = md_q;
        for (int i = 0; i < NUM_PTR; i++) st.ptr[i] = ptr_q[i];
    end
endmodule

// File: rtl/modal_regfile.sv
module modal_regfile
    import modal_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_sel_a,
    input  logic [SEL_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              rd_bad_a,
    output logic              rd_bad_b,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_bad,
    input  logic              ev_illegal,
    input  logic              ev_divzero,
    output logic              mode_ext,
    output logic              mode_firq_slow,
    output logic              mode_edge_trig,
    output logic              mode_irq_hold,
    output logic              mode_wide,
    output logic              mode_fpu,
    output logic              flag_illegal,
    output logic              flag_divzero,
    output logic [MASK_W-1:0] irq_mask
);
    arch_state_t       st;
    arch_state_t       wval;
    wr_enable_t        en;
    logic              ext, wide;
    logic [SEL_W-1:0]  rsel  [NUM_RD];
    logic [DATA_W-1:0] rdata [NUM_RD];
    logic              rbad  [NUM_RD];

    // Dependent enables only count while the extended level is on.
    assign ext  = st.md.ext_en;
    assign wide = st.md.ext_en & st.md.wide_en;

    mrf_write_decode u_wdec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ext     (ext),
        .wide    (wide),
        .wr_bad  (wr_bad),
        .en      (en),
        .wval    (wval)
    );

    mrf_store u_store (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .wval       (wval),
        .ev_illegal (ev_illegal),
        .ev_divzero (ev_divzero),
        .st         (st)
    );

    assign rsel[0] = rd_sel_a;
    assign rsel[1] = rd_sel_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mrf_read_port u_rd (
            .sel  (rsel[p]),
            .st   (st),
            .ext  (ext),
            .wide (wide),
            .data (rdata[p]),
            .bad  (rbad[p])
        );
    end

    assign rd_data_a = rdata[0];
    assign rd_data_b = rdata[1];
    assign rd_bad_a  = rbad[0];
    assign rd_bad_b  = rbad[1];

    assign mode_ext       = ext;
    assign mode_firq_slow = st.md.firq_slow;
    assign mode_edge_trig = st.md.edge_trig;
    assign mode_irq_hold  = st.md.irq_hold;
    assign mode_wide      = wide;
    assign mode_fpu       = ext & st.md.fpu_en;
    assign flag_illegal   = st.md.ill_flag;
    assign flag_divzero   = st.md.div_flag;
    assign irq_mask       = wide ? st.irq_mask : '0;
endmodule

// File: rtl/modal_regfile_chk.sv
module modal_regfile_chk
    import modal_regfile_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  rd_sel_a,
    input logic [SEL_W-1:0]  rd_sel_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              rd_bad_a,
    input logic              rd_bad_b,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_bad,
    input logic              ev_illegal,
    input logic              ev_divzero,
    input logic              mode_ext,
    input logic              mode_firq_slow,
    input logic              mode_edge_trig,
    input logic              mode_irq_hold,
    input logic              mode_wide,
    input logic              mode_fpu,
    input logic              flag_illegal,
    input logic              flag_divzero,
    input logic [MASK_W-1:0] irq_mask
);
    logic mode_wr;
    assign mode_wr = wr_en && (wr_sel == RC_MODE);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mode_ext && !flag_illegal && !flag_divzero && irq_mask == '0));

    assert_wide_needs_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_wide || mode_fpu) |-> mode_ext);

    assert_ctrl_bits_R2: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_firq_slow == $past(wr_data[1]) && mode_edge_trig == $past(wr_data[2])
                     && mode_irq_hold == $past(wr_data[3])));

    assert_bad_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_bad_a |-> rd_data_a == '0) and (rd_bad_b |-> rd_data_b == '0));

    assert_base_hides_e_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_ext && rd_sel_a == RC_E) |-> rd_bad_a);

    assert_bad_write_R3: assert property (@(posedge clk) disable iff (rst)
        wr_bad |-> (wr_en && !mode_wr));

    assert_d_over_a_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_a == RC_D && rd_sel_b == RC_A) |-> rd_data_a[15:8] == rd_data_b[7:0]);

    assert_narrow_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode_wide && rd_sel_a == RC_X) |-> rd_data_a[DATA_W-1:NARROW_W] == '0);

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_a == RC_ZERO && !mode_wide) |-> (rd_data_a == '0 && !rd_bad_a));

    assert_mask_hidden_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_wide |-> irq_mask == '0);

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_wide && wr_data[0] && wr_data[4]) |=> irq_mask == $past(wr_data[31:8]));

    assert_ill_set_R8: assert property (@(posedge clk) disable iff (rst)
        ev_illegal |=> flag_illegal);

    assert_dz_set_R8: assert property (@(posedge clk) disable iff (rst)
        ev_divzero |=> flag_divzero);

    assert_ill_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_illegal && !mode_wr) |=> flag_illegal);

    assert_ill_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !wr_data[6] && !ev_illegal) |=> !flag_illegal);

    assert_ports_agree_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_a == rd_sel_b) |-> (rd_data_a == rd_data_b && rd_bad_a == rd_bad_b));
endmodule

bind modal_regfile modal_regfile_chk chk_i (.*);

// File: tb/modal_regfile_tb_top.sv
module modal_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    localparam int C_D = 0, C_X = 1, C_PC = 5, C_W = 6, C_V = 7, C_A = 8, C_B = 9,
                   C_CC = 10, C_DP = 11, C_ZERO = 12, C_MODE = 13, C_E = 14, C_F = 15,
                   C_Q = 16, C_O = 17, C_DS = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
    logic [63:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        rd_bad_a, rd_bad_b, wr_bad;
    logic        wr_en = 1'b0, ev_illegal = 1'b0, ev_divzero = 1'b0;
    logic        mode_ext, mode_firq_slow, mode_edge_trig, mode_irq_hold;
    logic        mode_wide, mode_fpu, flag_illegal, flag_divzero;
    logic [23:0] irq_mask;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  m_a, m_b, m_e, m_f, m_cc, m_dp;
    logic [31:0] m_ptr [5];
    logic [31:0] m_v, m_md;
    logic [15:0] m_ds;

    always #(CLK_PERIOD/2) clk = ~clk;

    modal_regfile dut_i (.*);

    function automatic bit m_ext();  return m_md[0]; endfunction
    function automatic bit m_wide(); return m_md[0] & m_md[4]; endfunction

    function automatic bit ex_present(int sel);
        if (sel <= C_PC || sel == C_A || sel == C_B || sel == C_CC || sel == C_DP || sel == C_MODE)
            return 1'b1;
        if (sel == C_ZERO) return !m_wide();
        if (sel == C_E || sel == C_F || sel == C_W || sel == C_Q || sel == C_V) return m_ext();
        if (sel == C_O || sel == C_DS) return m_wide();
        return 1'b0;
    endfunction

    function automatic int ex_bits(int sel);
        if (sel == C_A || sel == C_B || sel == C_E || sel == C_F || sel == C_CC || sel == C_DP) return 8;
        if (sel == C_D || sel == C_W || sel == C_ZERO || sel == C_DS) return 16;
        if (sel == C_Q) return 32;
        if (sel == C_O) return 64;
        if (sel == C_MODE) return m_wide() ? 32 : 8;
        return m_wide() ? 32 : 16;
    endfunction

    function automatic logic [63:0] ex_mask(int sel);
        int w = ex_bits(sel);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ex_read(int sel);
        logic [63:0] r = '0;
        if (!ex_present(sel)) return '0;
        if (sel >= C_X && sel <= C_PC) r = {32'h0, m_ptr[sel-1]};
        else if (sel == C_A)    r = {56'h0, m_a};
        else if (sel == C_B)    r = {56'h0, m_b};
        else if (sel == C_E)    r = {56'h0, m_e};
        else if (sel == C_F)    r = {56'h0, m_f};
        else if (sel == C_CC)   r = {56'h0, m_cc};
        else if (sel == C_DP)   r = {56'h0, m_dp};
        else if (sel == C_D)    r = {48'h0, m_a, m_b};
        else if (sel == C_W)    r = {48'h0, m_e, m_f};
        else if (sel == C_Q)    r = {32'h0, m_a, m_b, m_e, m_f};
        else if (sel == C_O)    r = {m_a, m_b, m_e, m_f, m_v};
        else if (sel == C_V)    r = {32'h0, m_v};
        else if (sel == C_DS)   r = {48'h0, m_ds};
        else if (sel == C_MODE) r = {32'h0, m_md};
        return r & ex_mask(sel);
    endfunction

    task automatic model_reset();
        m_a = '0; m_b = '0; m_e = '0; m_f = '0; m_cc = '0; m_dp = '0;
        m_v = '0; m_md = '0; m_ds = '0;
        for (int i = 0; i < 5; i++) m_ptr[i] = '0;
    endtask

    task automatic model_update(bit we, int sel, logic [63:0] d, bit il, bit dz);
        logic [63:0] dm;
        if (we && ex_present(sel)) begin
            dm = d & ex_mask(sel);
            if (sel >= C_X && sel <= C_PC) m_ptr[sel-1] = dm[31:0];
            else if (sel == C_A)  m_a = dm[7:0];
            else if (sel == C_B)  m_b = dm[7:0];
            else if (sel == C_E)  m_e = dm[7:0];
            else if (sel == C_F)  m_f = dm[7:0];
            else if (sel == C_CC) m_cc = dm[7:0];
            else if (sel == C_DP) m_dp = dm[7:0];
            else if (sel == C_D)  {m_a, m_b} = dm[15:0];
            else if (sel == C_W)  {m_e, m_f} = dm[15:0];
            else if (sel == C_Q)  {m_a, m_b, m_e, m_f} = dm[31:0];
            else if (sel == C_O)  {m_a, m_b, m_e, m_f, m_v} = dm;
            else if (sel == C_V)  m_v = dm[31:0];
            else if (sel == C_DS) m_ds = dm[15:0];
            else if (sel == C_MODE) m_md = dm[31:0];
        end
        m_md[6] = m_md[6] | il;
        m_md[7] = m_md[7] | dz;
    endtask

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge, then advance the model.
    task automatic step(string req, int sa, int sb, bit we, int ws, logic [63:0] wd, bit il, bit dz);
        @(negedge clk);
        rd_sel_a = 5'(sa); rd_sel_b = 5'(sb);
        wr_en = we; wr_sel = 5'(ws); wr_data = wd;
        ev_illegal = il; ev_divzero = dz;
        #1;
        check(req, "rd_data_a", rd_data_a, ex_read(sa));
        check(req, "rd_data_b", rd_data_b, ex_read(sb));
        check(req, "rd_bad", {62'h0, rd_bad_a, rd_bad_b}, {62'h0, !ex_present(sa), !ex_present(sb)});
        check(req, "wr_bad", {63'h0, wr_bad}, {63'h0, we && !ex_present(ws)});
        check(req, "mode_bits",
              {56'h0, flag_divzero, flag_illegal, mode_fpu, mode_wide,
               mode_irq_hold, mode_edge_trig, mode_firq_slow, mode_ext},
              {56'h0, m_md[7], m_md[6], m_md[0] & m_md[5], m_wide(),
               m_md[3], m_md[2], m_md[1], m_md[0]});
        check(req, "irq_mask", {40'h0, irq_mask}, m_wide() ? {40'h0, m_md[31:8]} : 64'h0);
        @(posedge clk);
        model_update(we, ws, wd, il, dz);
    endtask

    function automatic int rnd_sel();
        if ($urandom_range(0, 9) == 0) return int'($urandom_range(19, 31));
        return int'($urandom_range(0, 18));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything clear after reset, base level
        step("R1", C_D, C_MODE, 1'b0, 0, '0, 0, 0);
        step("R1", C_X, C_E, 1'b0, 0, '0, 0, 0);

        // R4: D built from A and B, with literal expectation
        step("R4", C_A, C_B, 1'b1, C_A, 64'h12, 0, 0);
        step("R4", C_A, C_B, 1'b1, C_B, 64'h34, 0, 0);
        step("R4", C_D, C_A, 1'b0, 0, '0, 0, 0);
        check("R4", "D literal", rd_data_a, 64'h1234);

        // R3: base level hides E; write to E is refused
        step("R3", C_E, C_Q, 1'b1, C_E, 64'hAA, 0, 0);
        check("R3", "wr_bad on E in base", {63'h0, wr_bad}, 64'h1);

        // R6: zero register write has no effect
        step("R6", C_ZERO, C_D, 1'b1, C_ZERO, 64'hFFFF, 0, 0);
        step("R6", C_ZERO, C_D, 1'b0, 0, '0, 0, 0);
        check("R6", "D after zero write", rd_data_b, 64'h1234);

        // R5: narrow pointer write truncates
        step("R5", C_X, C_PC, 1'b1, C_X, 64'hDEAD_BEEF_CAFE_1357, 0, 0);
        step("R5", C_X, C_PC, 1'b0, 0, '0, 0, 0);
        check("R5", "X narrow literal", rd_data_a, 64'h1357);

        // R7: enter 32-bit level with a mask
        step("R7", C_MODE, C_ZERO, 1'b1, C_MODE, 64'h00AB_CD11, 0, 0);
        step("R7", C_MODE, C_ZERO, 1'b1, C_MODE, 64'h00AB_CD11, 0, 0);
        step("R7", C_O, C_DS, 1'b1, C_O, 64'h0102_0304_0506_0708, 0, 0);
        step("R4", C_O, C_Q, 1'b0, 0, '0, 0, 0);
        check("R4", "Q literal", rd_data_b, 64'h0102_0304);
        check("R7", "irq_mask literal", {40'h0, irq_mask}, 64'hAB_CD);

        // R8: event and flag-clearing write in the same cycle; then set and clear
        step("R8", C_MODE, C_A, 1'b1, C_MODE, 64'h11, 1, 1);
        step("R8", C_MODE, C_A, 1'b0, 0, '0, 0, 0);
        check("R8", "flags after collide", {62'h0, flag_divzero, flag_illegal}, 64'h3);
        step("R8", C_MODE, C_A, 1'b1, C_MODE, 64'h11, 0, 0);
        step("R8", C_MODE, C_A, 1'b0, 0, '0, 0, 0);
        check("R8", "flags cleared", {62'h0, flag_divzero, flag_illegal}, 64'h0);

        // R9: write visible one cycle later, ports agree
        step("R9", C_DP, C_DP, 1'b1, C_DP, 64'h5A, 0, 0);
        step("R9", C_DP, C_DP, 1'b0, 0, '0, 0, 0);
        check("R9", "DP literal", rd_data_a, 64'h5A);

        // R2: FPU enable ignored outside extended level
        step("R2", C_MODE, C_V, 1'b1, C_MODE, 64'h30, 0, 0);
        step("R2", C_MODE, C_V, 1'b0, 0, '0, 0, 0);
        check("R2", "fpu/wide off", {62'h0, mode_fpu, mode_wide}, 64'h0);

        for (int i = 0; i < N_RANDOM; i++) begin
            bit          we = ($urandom_range(0, 3) != 0);
            int          ws = ($urandom_range(0, 7) == 0) ? C_MODE : rnd_sel();
            logic [63:0] wd = {$urandom, $urandom};
            bit          il = ($urandom_range(0, 15) == 0);
            bit          dz = ($urandom_range(0, 15) == 0);
            step("RND", rnd_sel(), rnd_sel(), we, ws, wd, il, dz);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule